// File: doc/BRIEF.md
# Timer Input Capture Unit

This block takes a snapshot of a free-running 16-bit timer when a chosen event occurs on an external input. The input is asynchronous to the block clock. It passes through a two-flop synchronizer, and an edge is detected by comparing the synchronized sample with the sample from the cycle before. A 4-bit mode value selects the event: every falling edge, every rising edge, every 4th rising edge or every 16th rising edge. Any other mode value turns the unit off.

Each capture copies the whole timer word into the capture register and raises a sticky flag. The flag stays set until software clears it. If software does not read the register before the next capture, the new value overwrites the old one and nothing reports the loss.

A 4-bit prescaler counter counts rising edges in every capture mode. It is cleared only on reset or while the unit is outside capture mode. Changing directly from one prescale ratio to another therefore keeps the partial count. To start from a clean count, software writes the off mode first and then the new mode.

Top module: `tcap_unit`

## Requirements
- R1: When the mode register holds 4'b0000 or any value not listed in R2 to R4, no capture happens: `cap_value` and `cap_flag` keep their values whatever the capture input does.
- R2: In mode 4'b0100, every falling edge of the capture input causes a capture, and rising edges cause none.
- R3: In mode 4'b0101, every rising edge causes a capture, and falling edges cause none.
- R4: In mode 4'b0110, one rising edge in four causes a capture. In mode 4'b0111, one rising edge in sixteen causes a capture.
- R5: A capture copies all 16 bits of `timer_val` into `cap_value`. After the capture input changes between clock edges, the new value appears just after the third rising clock edge. The sampled `timer_val` is the one present before that third edge.
- R6: A capture sets `cap_flag`. The flag stays set until `flag_clr` is high at a clock edge with no capture at that edge; it then reads 0 after that edge.
- R7: If `flag_clr` and a capture fall on the same clock edge, the capture wins and `cap_flag` stays 1.
- R8: A new capture overwrites `cap_value` even when the flag is still set from an earlier capture that has not been read.
- R9: The 4-bit prescaler count is 0 after reset and while the mode is outside capture mode. Starting from count 0, in mode 4'b0110 the 4th rising edge captures, and in mode 4'b0111 the 16th rising edge captures.
- R10: In every capture mode, each rising edge advances the count modulo 16. Switching directly between prescale modes does not clear the count. A divide-by-4 capture happens when the low two bits of the count before the edge are 2'b11. A divide-by-16 capture happens when all four bits are 4'b1111.
- R11: A clock edge with `cfg_we` high loads `cfg_wdata` into the mode register. `mode_q` shows the register and is 4'b0000 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_in | input | 1 | Asynchronous capture input |
| timer_val | input | 16 | Current value of the free-running timer |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 4 | Mode value to write |
| mode_q | output | 4 | Current mode register contents |
| cap_value | output | 16 | Capture register read port |
| cap_flag | output | 1 | Sticky capture flag |
| flag_clr | input | 1 | Software clear for the flag |

## Verification
Assertions check four rules on every cycle:
- The flag stays set unless it is cleared.
- A capture that coincides with a clear leaves the flag set.
- Every change of the capture register comes with the flag set.
- The prescaler count is zero in the cycle after any non-capture mode, and the unit never captures while it is off.

Only the bench scenarios can show the event-selection rules and the latency:
- which edge each mode selects;
- the three-edge delay;
- which partial count lets the first capture come early after a direct switch between prescale ratios.

The bench checks these against a count model of its own.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    localparam int TMR_W  = 16;
    localparam int MODE_W = 4;
    localparam int PS_W   = 4;

    typedef enum logic [MODE_W-1:0] {
        CM_OFF    = 4'b0000,
        CM_FALL   = 4'b0100,
        CM_RISE   = 4'b0101,
        CM_RISE4  = 4'b0110,
        CM_RISE16 = 4'b0111
    } cap_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    // True for any mode that performs captures.
    function automatic logic mode_active(input logic [MODE_W-1:0] m);
        return (m[3:2] == 2'b01);
    endfunction

    // True for the modes that act on rising edges.
    function automatic logic mode_rising(input logic [MODE_W-1:0] m);
        return (m == CM_RISE) || (m == CM_RISE4) || (m == CM_RISE16);
    endfunction

    // Count bits that must all be ones for a rising edge to capture.
    function automatic logic [PS_W-1:0] ps_mask(input logic [MODE_W-1:0] m);
        case (m)
            CM_RISE4:  return 4'b0011;
            CM_RISE16: return 4'b1111;
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/tcap_edge_sync.sv
module tcap_edge_sync
    import tcap_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  async_in,
    output edge_t edges
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[TOP];
    end

    always_comb begin
        edges.rise = chain[TOP] & ~prev;
        edges.fall = ~chain[TOP] & prev;
    end

    // R3: a rising edge lasts for a single cycle
    assert_rise_single_R3: assert property (@(posedge clk) disable iff (rst)
        edges.rise |=> !edges.rise);

    // R2: a falling edge lasts for a single cycle
    assert_fall_single_R2: assert property (@(posedge clk) disable iff (rst)
        edges.fall |=> !edges.fall);

endmodule

// File: rtl/tcap_prescaler.sv
module tcap_prescaler
    import tcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  edge_t             edges,
    output logic              fire
);
    logic [PS_W-1:0] cnt;
    logic            active;
    logic            rise_hit;
    logic            fall_hit;

    always_comb begin
        active   = mode_active(mode);
        rise_hit = mode_rising(mode) && edges.rise
                   && ((cnt & ps_mask(mode)) == ps_mask(mode));
        fall_hit = (mode == CM_FALL) && edges.fall;
        fire     = active && (rise_hit || fall_hit);
    end

    // The count is cleared only by reset or a non-capture mode.
    always_ff @(posedge clk) begin
        if (rst || !active)   cnt <= '0;
        else if (edges.rise)  cnt <= cnt + 1'b1;
    end

    // R9: the count is zero after any cycle spent outside capture mode
    assert_cnt_clear_R9: assert property (@(posedge clk) disable iff (rst)
        !mode_active(mode) |=> (cnt == '0));

    // R10: a rising edge in capture mode advances the count by one
    assert_cnt_step_R10: assert property (@(posedge clk) disable iff (rst)
        (mode_active(mode) && edges.rise) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
    import tcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_in,
    input  logic [TMR_W-1:0]  timer_val,
    input  logic              cfg_we,
    input  logic [MODE_W-1:0] cfg_wdata,
    output logic [MODE_W-1:0] mode_q,
    output logic [TMR_W-1:0]  cap_value,
    output logic              cap_flag,
    input  logic              flag_clr
);
    edge_t edges;
    logic  fire;

    always_ff @(posedge clk) begin
        if (rst)         mode_q <= CM_OFF;
        else if (cfg_we) mode_q <= cfg_wdata;
    end

    tcap_edge_sync #(.STAGES(2)) i_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (cap_in),
        .edges    (edges)
    );

    tcap_prescaler i_presc (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode_q),
        .edges (edges),
        .fire  (fire)
    );

    always_ff @(posedge clk) begin
        if (rst)       cap_value <= '0;
        else if (fire) cap_value <= timer_val;
    end

    // A capture outranks a clear arriving at the same edge.
    always_ff @(posedge clk) begin
        if (rst)           cap_flag <= 1'b0;
        else if (fire)     cap_flag <= 1'b1;
        else if (flag_clr) cap_flag <= 1'b0;
    end

    // R6: the flag holds until it is cleared
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (cap_flag && !flag_clr) |=> cap_flag);

    // R7: a capture that meets a clear leaves the flag set
    assert_capture_beats_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (fire && flag_clr) |=> cap_flag);

    // R5: every change of the capture register comes with the flag set
    assert_load_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(cap_value) |-> cap_flag);

    // R1: an inactive unit leaves the capture register alone
    assert_idle_holds_R1: assert property (@(posedge clk) disable iff (rst)
        !mode_active(mode_q) |=> $stable(cap_value));

endmodule

// File: tb/test_tcap_unit.sv
module test_tcap_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_in = 1'b0;
    logic [15:0] timer_val = 16'h0000;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_wdata = 4'h0;
    logic [3:0]  mode_q;
    logic [15:0] cap_value;
    logic        cap_flag;
    logic        flag_clr = 1'b0;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // Bench model state
    logic [3:0]  m_mode = 4'h0;
    logic [3:0]  m_cnt = 4'h0;
    logic        m_lvl = 1'b0;
    logic [15:0] m_val = 16'h0;
    logic        m_flag = 1'b0;

    always #10 clk = ~clk;

    tcap_unit i_tcap_unit (
        .clk       (clk),
        .rst       (rst),
        .cap_in    (cap_in),
        .timer_val (timer_val),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .mode_q    (mode_q),
        .cap_value (cap_value),
        .cap_flag  (cap_flag),
        .flag_clr  (flag_clr)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic mdl_active(input logic [3:0] m);
        return m[3:2] == 2'b01;
    endfunction

    function automatic logic [3:0] mdl_mask(input logic [3:0] m);
        if (m == 4'b0110) return 4'b0011;
        if (m == 4'b0111) return 4'b1111;
        return 4'b0000;
    endfunction

    function automatic logic mdl_fire(input logic [3:0] m, input logic [3:0] c,
                                      input logic rose, input logic fell);
        logic rmode;
        rmode = (m == 4'b0101) || (m == 4'b0110) || (m == 4'b0111);
        if (!mdl_active(m)) return 1'b0;
        if (m == 4'b0100) return fell;
        return rmode && rose && ((c & mdl_mask(m)) == mdl_mask(m));
    endfunction

    task automatic set_mode(input logic [3:0] m, input string req);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = m;
        @(negedge clk);
        cfg_we = 1'b0;
        m_mode = m;
        if (!mdl_active(m)) m_cnt = 4'h0;
        chk(mode_q == m, req, mode_q, m);
    endtask

    // Toggle the capture input; optionally clear the flag on the capture edge.
    task automatic toggle(input logic clr_at_edge, input string req);
        logic rose, fell, f;
        logic [15:0] tv;
        @(negedge clk);
        tv = 16'($urandom);
        cap_in = ~m_lvl;
        timer_val = tv;
        rose = ~m_lvl;
        fell = m_lvl;
        m_lvl = ~m_lvl;
        f = mdl_fire(m_mode, m_cnt, rose, fell);
        if (mdl_active(m_mode) && rose) m_cnt = m_cnt + 4'h1;
        repeat (2) @(negedge clk);
        flag_clr = clr_at_edge;
        @(negedge clk);
        flag_clr = 1'b0;
        if (f) begin
            m_val = tv;
            m_flag = 1'b1;
        end else if (clr_at_edge) begin
            m_flag = 1'b0;
        end
        chk(cap_value == m_val, req, cap_value, m_val);
        chk(cap_flag == m_flag, req, cap_flag, m_flag);
    endtask

    task automatic rises(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            toggle(1'b0, req);
            toggle(1'b0, req);
        end
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        m_flag = 1'b0;
        chk(cap_flag == 1'b0, "R6 clear", cap_flag, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state (R11, R5, R6)
        chk(mode_q == 4'h0, "R11 reset mode", mode_q, 0);
        chk(cap_value == 16'h0, "R5 reset value", cap_value, 0);
        chk(cap_flag == 1'b0, "R6 reset flag", cap_flag, 0);

        // R1: off and an unlisted code
        rises(2, "R1 off");
        set_mode(4'b1010, "R11 write");
        rises(2, "R1 unlisted");

        // R2: falling-edge mode
        set_mode(4'b0100, "R11 write");
        toggle(1'b0, "R2 rise ignored");
        toggle(1'b0, "R2 fall captures");
        clear_flag();

        // R3 and R8: rising-edge mode, overwrite without clear
        set_mode(4'b0101, "R11 write");
        toggle(1'b0, "R3 rise captures");
        toggle(1'b0, "R3 fall ignored");
        toggle(1'b0, "R8 overwrite");
        toggle(1'b0, "R3 fall ignored");
        clear_flag();

        // R4 and R9: divide by 4 and 16 from a clean count
        set_mode(4'b0000, "R9 off");
        set_mode(4'b0110, "R11 write");
        rises(4, "R4 div4");
        clear_flag();
        set_mode(4'b0000, "R9 off");
        set_mode(4'b0111, "R11 write");
        rises(16, "R4 div16");
        clear_flag();

        // R10: direct switch from /16 to /4 keeps the partial count
        set_mode(4'b0000, "R9 off");
        set_mode(4'b0111, "R11 write");
        rises(10, "R10 partial");
        set_mode(4'b0110, "R10 switch");
        rises(2, "R10 early capture");

        // R7: capture and clear on the same edge
        set_mode(4'b0101, "R11 write");
        toggle(1'b1, "R7 capture beats clear");

        // Constrained random mix
        for (int k = 0; k < 400; k++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel == 0) begin
                logic [3:0] nm;
                nm = ($urandom_range(0, 4) == 0) ? 4'($urandom) : 4'(3'd4 + $urandom_range(0, 3));
                set_mode(nm, "R11 random mode");
            end else if (sel == 1) begin
                clear_flag();
            end else if (sel == 2) begin
                toggle(1'b1, "R7 random clear");
            end else begin
                toggle(1'b0, "R10 random edge");
            end
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule